// File: doc/BRIEF.md
# Five-State Coherent Cache Line Controller

This block keeps the coherence state of a small set of cache lines for one cache in a snooping multiprocessor. Each line is described on two axes: whether the copy may be held by other caches (shared or unique) and whether it differs from memory (clean or dirty). Together with an invalid state, this gives five states. A shared-dirty line may be held by several caches. Exactly one cache holds it as shared-dirty and is the one that must write it back. The others hold it as shared-clean. Data storage, bus arbitration and memory sit outside the block.

The local side issues read, write and evict requests, each carrying a line index. A read miss issues a bus read. A write to a line that is not unique raises an upgrade request and completes when the grant arrives. Evicting a dirty line raises a one-cycle write-back. The snoop side takes remote reads and remote write-invalidates. It answers within the same cycle whether the line is held, and it reports a data supply (forward) or a write-back on the following cycle. A registered query port reads the state of any line. Two or more instances share one snoop bus. In that setup, each cache's shared input is driven by the other caches' snoop-shared outputs.

Top module: `coh_line_ctrl`

## Requirements
- R1: After a synchronous reset, every line reads invalid, loc_ready is 1, and loc_done, bus_rd, bus_upg, wb_req and snp_fwd are 0.
- R2: qry_state returns the line state as {valid, unique, dirty}: invalid 3'b000, shared-clean 3'b100, shared-dirty 3'b101, unique-clean 3'b110, unique-dirty 3'b111. It reflects the state one cycle after qry_idx is applied.
- R3: A local read (loc_op 0) to an invalid line pulses bus_rd for one cycle and fills the line as unique-clean when shared_in is 0, or as shared-clean when shared_in is 1. A read to a valid line raises no bus_rd and leaves the state unchanged.
- R4: A local write (loc_op 1) to a unique line sets it to unique-dirty and completes with no bus_rd and no bus_upg.
- R5: A local write to a shared or invalid line holds bus_upg high and loc_ready low, and leaves the line unchanged until upg_grant is seen. At the grant, the line becomes unique-dirty, bus_upg falls, loc_ready rises and loc_done pulses.
- R6: A snoop read (snp_op 0) moves unique-dirty to shared-dirty and unique-clean to shared-clean. Shared and invalid lines are left as they are. snp_fwd pulses for a unique or shared-dirty line, and a snoop read never raises wb_req.
- R7: A snoop write-invalidate (snp_op 1) sets any valid line to invalid. wb_req pulses, with wb_idx equal to the snooped index, only when the line was unique-dirty.
- R8: A local evict (loc_op 2) of a unique-dirty or shared-dirty line pulses wb_req with wb_idx equal to the line index, and the line becomes invalid. Evicting a clean line invalidates it with no write-back.
- R9: snp_shared is 1 in the same cycle exactly when snp_valid is 1 and the snooped line is valid.
- R10: A local request is accepted only in a cycle with snp_valid low; otherwise it has no effect until it is presented again. loc_done pulses for exactly one cycle after each completed request.
- R11: Across caches sharing the snoop bus, at most one cache holds a given line in a dirty state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_valid | input | 1 | Local request present |
| loc_op | input | 2 | Local operation: 0 read, 1 write, 2 evict |
| loc_idx | input | IW | Local line index |
| loc_ready | output | 1 | No upgrade outstanding |
| loc_done | output | 1 | One-cycle pulse when a local request completes |
| shared_in | input | 1 | Another cache holds the line being filled |
| bus_rd | output | 1 | One-cycle bus read for a read miss |
| bus_upg | output | 1 | Upgrade request, held until granted |
| upg_grant | input | 1 | Upgrade granted |
| snp_valid | input | 1 | Snoop request present |
| snp_op | input | 1 | Snoop operation: 0 read, 1 write-invalidate |
| snp_idx | input | IW | Snooped line index |
| snp_shared | output | 1 | Same-cycle answer: snooped line is valid here |
| snp_fwd | output | 1 | One-cycle pulse: this cache supplies the data |
| wb_req | output | 1 | One-cycle write-back request |
| wb_idx | output | IW | Index of the line to write back |
| qry_idx | input | IW | Line index to query |
| qry_state | output | 3 | Queried state {valid, unique, dirty} |

## Verification
The assertions check on every cycle that an outstanding upgrade keeps loc_ready low and that a grant completes it on the next cycle. They also check that a bus read always comes with its completion pulse, that completion pulses never fall on consecutive cycles, that a forward and a write-back never coincide, and that a snoop never produces a unique state. The bench's two-cache scenarios are needed to show the state transitions themselves: ownership passing from unique-dirty to shared-dirty, an owner invalidated by another cache's upgrade, and write-back only from the dirty owner. They also show that at most one cache holds a line dirty, and that the shared answer of one cache steers the fill state of the other.

// File: rtl/coh_pkg.sv
package coh_pkg;
  // line state as {valid, unique, dirty}
  typedef enum logic [2:0] {
    ST_INV = 3'b000,
    ST_SC  = 3'b100,
    ST_SD  = 3'b101,
    ST_UC  = 3'b110,
    ST_UD  = 3'b111
  } cstate_t;

  localparam int VBIT = 2;
  localparam int UBIT = 1;
  localparam int DBIT = 0;

  localparam logic [1:0] LOP_RD = 2'd0;
  localparam logic [1:0] LOP_WR = 2'd1;
  localparam logic [1:0] LOP_EV = 2'd2;

  localparam logic SOP_RD = 1'b0;
  localparam logic SOP_WI = 1'b1;
endpackage

// File: rtl/coh_line_bank.sv
module coh_line_bank #(
  parameter int NLINES = 8,
  parameter int IW     = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] sn_ridx,
  output logic [2:0]    sn_rstate,
  input  logic [IW-1:0] lc_ridx,
  output logic [2:0]    lc_rstate,
  input  logic [IW-1:0] q_ridx,
  output logic [2:0]    q_rstate,
  input  logic          sn_wen,
  input  logic [IW-1:0] sn_widx,
  input  logic [2:0]    sn_wval,
  input  logic          lc_wen,
  input  logic [IW-1:0] lc_widx,
  input  logic [2:0]    lc_wval
);
  import coh_pkg::*;

  logic [NLINES-1:0][2:0] lines;

  // local write has priority when both ports hit one line
  always_ff @(posedge clk) begin
    if (rst) begin
      lines <= '0;
    end else begin
      for (int k = 0; k < NLINES; k++) begin
        if (lc_wen && (lc_widx == IW'(k)))
          lines[k] <= lc_wval;
        else if (sn_wen && (sn_widx == IW'(k)))
          lines[k] <= sn_wval;
      end
    end
  end

  assign sn_rstate = lines[sn_ridx];
  assign lc_rstate = lines[lc_ridx];
  assign q_rstate  = lines[q_ridx];

  // R1: first cycle out of reset sees every line invalid
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lines == '0));
endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit (
  input  logic       snp_valid,
  input  logic       snp_op,
  input  logic [2:0] cur,
  output logic       wen,
  output logic [2:0] nxt,
  output logic       wb,
  output logic       fwd,
  output logic       shared
);
  import coh_pkg::*;

  always_comb begin
    wen    = 1'b0;
    nxt    = cur;
    wb     = 1'b0;
    fwd    = 1'b0;
    shared = snp_valid && cur[VBIT];
    if (snp_valid && cur[VBIT]) begin
      if (snp_op == SOP_RD) begin
        fwd = cur[UBIT] | cur[DBIT];
        if (cur[UBIT]) begin
          wen = 1'b1;
          nxt = {1'b1, 1'b0, cur[DBIT]};
        end
      end else begin
        wen = 1'b1;
        nxt = ST_INV;
        wb  = (cur == ST_UD);
      end
    end
  end

  // R6 / R7: a snoop never leaves a line unique
  always_comb begin
    if (wen) p_snoop_no_unique_r6: assert (!nxt[UBIT]);
  end
endmodule

// File: rtl/coh_local_fsm.sv
module coh_local_fsm #(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          loc_valid,
  input  logic [1:0]    loc_op,
  input  logic [IW-1:0] loc_idx,
  input  logic          snp_valid,
  input  logic [2:0]    cur,
  input  logic          shared_in,
  input  logic          upg_grant,
  output logic          wen,
  output logic [IW-1:0] widx,
  output logic [2:0]    wval,
  output logic          ev_wb,
  output logic          bus_rd,
  output logic          bus_upg,
  output logic          loc_ready,
  output logic          loc_done
);
  import coh_pkg::*;

  typedef enum logic {F_IDLE, F_WAIT} fst_t;
  fst_t          st;
  logic [IW-1:0] hold_idx;
  logic          acc, rd_miss, need_upg, grant_now;

  assign acc       = (st == F_IDLE) && loc_valid && !snp_valid && !loc_done;
  assign grant_now = (st == F_WAIT) && upg_grant;

  always_comb begin
    wen      = 1'b0;
    widx     = loc_idx;
    wval     = cur;
    ev_wb    = 1'b0;
    rd_miss  = 1'b0;
    need_upg = 1'b0;
    if (grant_now) begin
      wen  = 1'b1;
      widx = hold_idx;
      wval = ST_UD;
    end else if (acc) begin
      case (loc_op)
        LOP_RD: if (!cur[VBIT]) begin
          rd_miss = 1'b1;
          wen     = 1'b1;
          wval    = shared_in ? ST_SC : ST_UC;
        end
        LOP_WR: if (cur[UBIT]) begin
          wen  = 1'b1;
          wval = ST_UD;
        end else begin
          need_upg = 1'b1;
        end
        LOP_EV: if (cur[VBIT]) begin
          wen   = 1'b1;
          wval  = ST_INV;
          ev_wb = cur[DBIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= F_IDLE;
      hold_idx  <= '0;
      bus_rd    <= 1'b0;
      bus_upg   <= 1'b0;
      loc_ready <= 1'b1;
      loc_done  <= 1'b0;
    end else begin
      bus_rd   <= acc && rd_miss;
      loc_done <= (acc && !need_upg) || grant_now;
      if (acc && need_upg) begin
        st        <= F_WAIT;
        hold_idx  <= loc_idx;
        bus_upg   <= 1'b1;
        loc_ready <= 1'b0;
      end else if (grant_now) begin
        st        <= F_IDLE;
        bus_upg   <= 1'b0;
        loc_ready <= 1'b1;
      end
    end
  end

  // R5: an outstanding upgrade blocks new local requests
  p_upg_not_ready_r5: assert property (@(posedge clk) disable iff (rst)
    bus_upg |-> !loc_ready);
  // R5: a grant finishes the upgrade on the next cycle
  p_grant_completes_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_upg && upg_grant) |=> (loc_done && !bus_upg && loc_ready));
  // R3: a bus read always accompanies a completed read
  p_rd_done_r3: assert property (@(posedge clk) disable iff (rst)
    bus_rd |-> loc_done);
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl #(
  parameter int NLINES = 8,
  localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          loc_valid,
  input  logic [1:0]    loc_op,
  input  logic [IW-1:0] loc_idx,
  output logic          loc_ready,
  output logic          loc_done,
  input  logic          shared_in,
  output logic          bus_rd,
  output logic          bus_upg,
  input  logic          upg_grant,
  input  logic          snp_valid,
  input  logic          snp_op,
  input  logic [IW-1:0] snp_idx,
  output logic          snp_shared,
  output logic          snp_fwd,
  output logic          wb_req,
  output logic [IW-1:0] wb_idx,
  input  logic [IW-1:0] qry_idx,
  output logic [2:0]    qry_state
);
  logic [2:0]    sn_cur, lc_cur, q_cur, sn_nxt, lc_wval;
  logic          sn_wen, sn_wb, sn_fwd, lc_wen, lc_evwb;
  logic [IW-1:0] lc_widx;

  coh_line_bank #(.NLINES(NLINES), .IW(IW)) u_bank (
    .clk(clk), .rst(rst),
    .sn_ridx(snp_idx), .sn_rstate(sn_cur),
    .lc_ridx(loc_idx), .lc_rstate(lc_cur),
    .q_ridx(qry_idx),  .q_rstate(q_cur),
    .sn_wen(sn_wen), .sn_widx(snp_idx), .sn_wval(sn_nxt),
    .lc_wen(lc_wen), .lc_widx(lc_widx), .lc_wval(lc_wval)
  );

  coh_snoop_unit u_snoop (
    .snp_valid(snp_valid), .snp_op(snp_op), .cur(sn_cur),
    .wen(sn_wen), .nxt(sn_nxt), .wb(sn_wb), .fwd(sn_fwd),
    .shared(snp_shared)
  );

  coh_local_fsm #(.IW(IW)) u_local (
    .clk(clk), .rst(rst),
    .loc_valid(loc_valid), .loc_op(loc_op), .loc_idx(loc_idx),
    .snp_valid(snp_valid), .cur(lc_cur), .shared_in(shared_in),
    .upg_grant(upg_grant),
    .wen(lc_wen), .widx(lc_widx), .wval(lc_wval), .ev_wb(lc_evwb),
    .bus_rd(bus_rd), .bus_upg(bus_upg), .loc_ready(loc_ready),
    .loc_done(loc_done)
  );

  // snoop and local write-backs never share a cycle: local waits on snoops
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_req    <= 1'b0;
      wb_idx    <= '0;
      snp_fwd   <= 1'b0;
      qry_state <= '0;
    end else begin
      wb_req    <= sn_wb | lc_evwb;
      wb_idx    <= sn_wb ? snp_idx : loc_idx;
      snp_fwd   <= sn_fwd;
      qry_state <= q_cur;
    end
  end

  // R6: supplying data and writing back are never reported together
  p_fwd_no_wb_r6: assert property (@(posedge clk) disable iff (rst)
    snp_fwd |-> !wb_req);
  // R10: completion is a single-cycle pulse
  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    loc_done |=> !loc_done);
endmodule

// File: tb/sim_coh_line_ctrl.sv
module sim_coh_line_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;
  localparam int IW = $clog2(NL);
  localparam logic [2:0] S_I = 3'b000, S_SC = 3'b100, S_SD = 3'b101,
                         S_UC = 3'b110, S_UD = 3'b111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          lv[2], sv[2], so[2], gr[2];
  logic [1:0]    lo[2];
  logic [IW-1:0] li[2], si[2], qi[2], wbi[2];
  logic          shd[2], brd[2], upg[2], rdy[2], dn[2], wb[2], fwd[2];
  logic [2:0]    qs[2];
  logic [2:0]    mdl[2][NL];
  int checks = 0, fails = 0;

  coh_line_ctrl #(.NLINES(NL)) u0 (
    .clk(clk), .rst(rst), .loc_valid(lv[0]), .loc_op(lo[0]), .loc_idx(li[0]),
    .loc_ready(rdy[0]), .loc_done(dn[0]), .shared_in(shd[1]), .bus_rd(brd[0]),
    .bus_upg(upg[0]), .upg_grant(gr[0]), .snp_valid(sv[0]), .snp_op(so[0]),
    .snp_idx(si[0]), .snp_shared(shd[0]), .snp_fwd(fwd[0]), .wb_req(wb[0]),
    .wb_idx(wbi[0]), .qry_idx(qi[0]), .qry_state(qs[0]));

  coh_line_ctrl #(.NLINES(NL)) u1 (
    .clk(clk), .rst(rst), .loc_valid(lv[1]), .loc_op(lo[1]), .loc_idx(li[1]),
    .loc_ready(rdy[1]), .loc_done(dn[1]), .shared_in(shd[0]), .bus_rd(brd[1]),
    .bus_upg(upg[1]), .upg_grant(gr[1]), .snp_valid(sv[1]), .snp_op(so[1]),
    .snp_idx(si[1]), .snp_shared(shd[1]), .snp_fwd(fwd[1]), .wb_req(wb[1]),
    .wb_idx(wbi[1]), .qry_idx(qi[1]), .qry_state(qs[1]));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] snrd(input logic [2:0] s);
    return s[2] ? {1'b1, 1'b0, s[0]} : s;
  endfunction

  function automatic logic exp_fwd(input logic [2:0] s);
    return s[2] && (s[1] || s[0]);
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // R2 / R11: state of one line in both caches, plus single dirty holder
  task automatic check_line(input int i, input string tag);
    @(negedge clk);
    qi[0] = IW'(i); qi[1] = IW'(i);
    @(posedge clk); #1;
    chk({tag, " R2 u0 state"}, 32'(qs[0]), 32'(mdl[0][i]));
    chk({tag, " R2 u1 state"}, 32'(qs[1]), 32'(mdl[1][i]));
    chk("R11 dirty holders", 32'((qs[0][2] & qs[0][0]) & (qs[1][2] & qs[1][0])), 32'd0);
  endtask

  task automatic run_rd(input int c, input int i);
    int o = 1 - c;
    logic miss = !mdl[c][i][2];
    logic [2:0] oth = mdl[o][i];
    @(negedge clk);
    lv[c] = 1'b1; lo[c] = 2'd0; li[c] = IW'(i);
    if (miss) begin sv[o] = 1'b1; so[o] = 1'b0; si[o] = IW'(i); end
    #1;
    if (miss) chk("R9 snp_shared", 32'(shd[o]), 32'(oth[2]));
    @(posedge clk); #1;
    lv[c] = 1'b0; sv[o] = 1'b0;
    chk("R10 read done", 32'(dn[c]), 32'd1);
    chk("R3 bus_rd", 32'(brd[c]), 32'(miss));
    if (miss) begin
      chk("R6 fwd on remote read", 32'(fwd[o]), 32'(exp_fwd(oth)));
      chk("R6 no wb on snoop read", 32'(wb[o]), 32'd0);
      mdl[c][i] = oth[2] ? S_SC : S_UC;
      mdl[o][i] = snrd(oth);
    end
    check_line(i, "R3");
  endtask

  task automatic run_wr(input int c, input int i);
    int o = 1 - c;
    logic [2:0] cur = mdl[c][i];
    logic [2:0] oth;
    @(negedge clk);
    lv[c] = 1'b1; lo[c] = 2'd1; li[c] = IW'(i);
    @(posedge clk); #1;
    lv[c] = 1'b0;
    if (cur[1]) begin
      chk("R4 write done", 32'(dn[c]), 32'd1);
      chk("R4 no upgrade", 32'(upg[c]), 32'd0);
      chk("R4 no bus_rd", 32'(brd[c]), 32'd0);
      mdl[c][i] = S_UD;
      check_line(i, "R4");
    end else begin
      chk("R5 upgrade raised", 32'(upg[c]), 32'd1);
      chk("R5 not ready", 32'(rdy[c]), 32'd0);
      chk("R5 not done", 32'(dn[c]), 32'd0);
      check_line(i, "R5 waiting");
      repeat ($urandom % 3) @(posedge clk);
      oth = mdl[o][i];
      @(negedge clk);
      gr[c] = 1'b1; sv[o] = 1'b1; so[o] = 1'b1; si[o] = IW'(i);
      @(posedge clk); #1;
      gr[c] = 1'b0; sv[o] = 1'b0;
      chk("R5 grant done", 32'(dn[c]), 32'd1);
      chk("R5 upgrade dropped", 32'(upg[c]), 32'd0);
      chk("R5 ready again", 32'(rdy[c]), 32'd1);
      chk("R7 wb on invalidate", 32'(wb[o]), 32'(oth == S_UD));
      if (oth == S_UD) chk("R7 wb_idx", 32'(wbi[o]), 32'(i));
      mdl[o][i] = S_I;
      mdl[c][i] = S_UD;
      check_line(i, "R5");
    end
  endtask

  task automatic run_ev(input int c, input int i);
    logic [2:0] cur = mdl[c][i];
    logic dirty = cur[2] && cur[0];
    @(negedge clk);
    lv[c] = 1'b1; lo[c] = 2'd2; li[c] = IW'(i);
    @(posedge clk); #1;
    lv[c] = 1'b0;
    chk("R10 evict done", 32'(dn[c]), 32'd1);
    chk("R8 wb on evict", 32'(wb[c]), 32'(dirty));
    if (dirty) chk("R8 wb_idx", 32'(wbi[c]), 32'(i));
    mdl[c][i] = S_I;
    check_line(i, "R8");
  endtask

  task automatic run_snp(input int c, input logic op, input int i);
    logic [2:0] cur = mdl[c][i];
    @(negedge clk);
    sv[c] = 1'b1; so[c] = op; si[c] = IW'(i);
    #1;
    chk("R9 snp_shared", 32'(shd[c]), 32'(cur[2]));
    @(posedge clk); #1;
    sv[c] = 1'b0;
    if (op == 1'b0) begin
      chk("R6 fwd", 32'(fwd[c]), 32'(exp_fwd(cur)));
      chk("R6 no wb", 32'(wb[c]), 32'd0);
      mdl[c][i] = snrd(cur);
      check_line(i, "R6");
    end else begin
      chk("R7 wb", 32'(wb[c]), 32'(cur == S_UD));
      if (cur == S_UD) chk("R7 wb_idx", 32'(wbi[c]), 32'(i));
      chk("R7 no fwd", 32'(fwd[c]), 32'd0);
      mdl[c][i] = S_I;
      check_line(i, "R7");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog act=%0d exp=%0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      lv[c] = 0; sv[c] = 0; so[c] = 0; gr[c] = 0; lo[c] = 0;
      li[c] = '0; si[c] = '0; qi[c] = '0;
      for (int k = 0; k < NL; k++) mdl[c][k] = S_I;
    end
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    // R1 reset state
    for (int c = 0; c < 2; c++) begin
      chk("R1 ready", 32'(rdy[c]), 32'd1);
      chk("R1 outputs low", 32'({dn[c], brd[c], upg[c], wb[c], fwd[c]}), 32'd0);
    end
    for (int k = 0; k < NL; k++) check_line(k, "R1");

    // R10: local read held off by a snoop in the same cycle
    @(negedge clk);
    lv[0] = 1'b1; lo[0] = 2'd0; li[0] = IW'(3);
    sv[0] = 1'b1; so[0] = 1'b0; si[0] = IW'(5);
    @(posedge clk); #1;
    chk("R10 blocked no done", 32'(dn[0]), 32'd0);
    chk("R10 blocked no bus_rd", 32'(brd[0]), 32'd0);
    sv[0] = 1'b0;
    @(posedge clk); #1;
    lv[0] = 1'b0;
    chk("R10 accepted done", 32'(dn[0]), 32'd1);
    chk("R3 miss bus_rd", 32'(brd[0]), 32'd1);
    mdl[0][3] = S_UC;
    @(posedge clk); #1;
    chk("R10 done single pulse", 32'(dn[0]), 32'd0);
    check_line(3, "R3 unshared fill");

    // directed ownership walk on line 1
    run_rd(0, 1);  // u0 UC
    run_wr(0, 1);  // u0 UD, silent
    run_rd(1, 1);  // u0 SD with forward, u1 SC
    run_rd(1, 1);  // hit
    run_wr(1, 1);  // u1 upgrade, u0 SD dropped
    run_ev(1, 1);  // dirty evict
    run_rd(0, 1);
    run_ev(0, 1);  // clean evict
    // shared-dirty owner writes back on evict
    run_rd(0, 2); run_wr(0, 2); run_rd(1, 2); run_ev(0, 2);
    // snoops from a third agent
    run_rd(1, 4); run_wr(1, 4); run_snp(1, 1'b1, 4);
    run_rd(1, 6); run_snp(1, 1'b0, 6); run_snp(1, 1'b0, 6); run_snp(1, 1'b1, 6);

    for (int n = 0; n < 400; n++) begin
      int c = int'($urandom % 2);
      int i = int'($urandom % NL);
      case ($urandom % 4)
        0: run_rd(c, i);
        1: run_wr(c, i);
        2: run_ev(c, i);
        default: run_snp(c, logic'($urandom % 2), i);
      endcase
    end
    summary();
    $finish;
  end
endmodule